// File: doc/BRIEF.md
# Consumer-Index Register Access Gate

This block owns a single 64-bit control register that records where a hardware consumer is in a work structure: a two-bit error cause in the top bits and a read index in the low bits. It decides what happens to each software read or write of that register. The decision depends on the requester's privilege level (0 to 3), a three-bit nested-virtualisation control, whether the feature exists at all, whether the most privileged level is implemented and has enabled the feature, and a mode flag that picks between two orderings of "undefined" and "trap" when the feature is disabled at the top level.

A request has one of five outcomes: a direct register access, a redirect to a fixed memory offset (the memory system then does the access), a trap to level 2, a trap to level 3, or an undefined-instruction result. The outcome is registered and returned one cycle after the request, together with the read data or the effect of the write. Besides software writes, the consumer hardware can advance the index by one or load an error cause.

Top module: `ctlreg_access_gate`

## Requirements
- R1: When `feat_impl` is 0, every request gives the undefined outcome, whatever the other inputs are.
- R2: With the feature present, a request at privilege level 0 gives the undefined outcome.
- R3: At level 1 with `nv_ctl[2]` and `nv_ctl[0]` both 1 (`nv_ctl[1]` ignored), the outcome is a redirect with `rsp_mem_offset` = 0x308 and `rsp_rdata` zero; a redirected write leaves the register unchanged.
- R4: At level 1 with `nv_ctl[0]` = 1 and `nv_ctl[2]` = 0 the outcome is a trap to level 2; with `nv_ctl[0]` = 0 it is undefined. Both trap outcomes carry syndrome class 0x18; every other outcome carries syndrome 0.
- R5: At level 2, when `top_lvl_present` = 1, `top_lvl_enable` = 0 and `undef_prio_mode` = 1, the outcome is undefined.
- R6: At level 2, when `top_lvl_present` = 1, `top_lvl_enable` = 0 and `undef_prio_mode` = 0, the outcome is undefined if `undef_secondary` = 1 and a trap to level 3 otherwise.
- R7: At level 3, and at level 2 when the top level is absent or has the feature enabled, the outcome is direct: a read returns the register, a write stores it.
- R8: Each request with `req_valid` = 1 yields `rsp_valid` = 1 with exactly one outcome flag in the next cycle, with `rsp_write` echoing the request direction; without a request all response outputs are zero.
- R9: Register layout: bits 63:62 error cause (0 none, 1 structure read fault, 2 translation fault on an entry address, 3 other entry error), bits IDX_W-1:0 index (IDX_W = 12 by default); all other bits read as zero and writes to them are ignored; the register resets to zero.
- R10: `hw_idx_inc` advances the index by one, wrapping from all ones to zero, leaving the error cause alone.
- R11: `hw_err_load` loads `hw_err_code` into the error cause and suppresses a same-cycle increment; a direct software write in the same cycle wins over both hardware updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 64 | Write data |
| priv_lvl | input | 2 | Requester privilege level |
| nv_ctl | input | 3 | Nested-virtualisation control (bit 2 redirect, bit 0 enable) |
| feat_impl | input | 1 | Feature implemented |
| top_lvl_present | input | 1 | Level 3 implemented |
| top_lvl_enable | input | 1 | Feature enable from level 3 |
| undef_prio_mode | input | 1 | Undefined takes priority over level-3 trap |
| undef_secondary | input | 1 | Secondary undefined condition |
| hw_idx_inc | input | 1 | Hardware index increment |
| hw_err_load | input | 1 | Hardware error-cause load |
| hw_err_code | input | 2 | Error cause to load |
| rsp_valid | output | 1 | Response valid |
| rsp_write | output | 1 | Echo of request direction |
| rsp_direct | output | 1 | Direct register access |
| rsp_redirect | output | 1 | Redirect to memory offset |
| rsp_trap_l2 | output | 1 | Trap to level 2 |
| rsp_trap_l3 | output | 1 | Trap to level 3 |
| rsp_undef | output | 1 | Undefined instruction |
| rsp_syndrome | output | 6 | Trap syndrome class |
| rsp_mem_offset | output | 12 | Memory offset for redirect |
| rsp_rdata | output | 64 | Read data for direct reads |

## Verification
Every combination of level-1 nested-virtualisation bits and every combination of level-2 presence, enable, priority mode and secondary condition is driven as both read and write, which separates the two undefined-versus-trap orderings and shows the don't-care middle control bit has no effect. The feature-absent and level-0 sweeps show the top-priority undefined checks mask all other inputs. Register-side patterns (all-ones writes, index wrap, error load racing an increment and a software write) separate field masking from update priority, and a long random phase with all inputs free is compared against a behavioural model every cycle.

// File: rtl/acg_pkg.sv
package acg_pkg;

  typedef enum logic [2:0] {
    OC_DIRECT   = 3'd0,
    OC_REDIRECT = 3'd1,
    OC_TRAP_L2  = 3'd2,
    OC_TRAP_L3  = 3'd3,
    OC_UNDEF    = 3'd4
  } acg_outcome_e;

  typedef enum logic [1:0] {
    ERR_NONE        = 2'd0,
    ERR_STRUCT_READ = 2'd1,
    ERR_XLAT_FAULT  = 2'd2,
    ERR_ENTRY_OTHER = 2'd3
  } acg_err_e;

  localparam int unsigned REG_W      = 64;
  localparam int unsigned ERR_HI     = 63;
  localparam int unsigned ERR_LO     = 62;
  localparam int unsigned NV_W       = 3;
  localparam int unsigned NV_REDIR   = 2;
  localparam int unsigned NV_ENABLE  = 0;
  localparam int unsigned SYN_W      = 6;
  localparam logic [SYN_W-1:0] SYN_SYSREG = 6'h18;

endpackage

// File: rtl/acg_decide.sv
module acg_decide
  import acg_pkg::*;
(
  input  logic                 feat_impl,
  input  logic [1:0]           priv_lvl,
  input  logic [NV_W-1:0]      nv_ctl,
  input  logic                 top_present,
  input  logic                 top_enable,
  input  logic                 prio_mode,
  input  logic                 sec_undef,
  output acg_outcome_e         outcome
);

  logic nv_redir;
  logic nv_en;
  logic top_blocks;
  logic unused_nv;

  assign nv_redir   = nv_ctl[NV_REDIR];
  assign nv_en      = nv_ctl[NV_ENABLE];
  assign top_blocks = top_present && !top_enable;
  assign unused_nv  = ^nv_ctl;

  always_comb begin
    outcome = OC_UNDEF;
    if (feat_impl) begin
      unique case (priv_lvl)
        2'd0: outcome = OC_UNDEF;
        2'd1: begin
          if (nv_redir && nv_en)  outcome = OC_REDIRECT;
          else if (nv_en)         outcome = OC_TRAP_L2;
          else                    outcome = OC_UNDEF;
        end
        2'd2: begin
          if (top_blocks) begin
            if (prio_mode)        outcome = OC_UNDEF;
            else if (sec_undef)   outcome = OC_UNDEF;
            else                  outcome = OC_TRAP_L3;
          end else begin
            outcome = OC_DIRECT;
          end
        end
        default: outcome = OC_DIRECT;
      endcase
    end
  end

endmodule

// File: rtl/acg_consreg.sv
module acg_consreg
  import acg_pkg::*;
#(
  parameter int unsigned IDX_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_we,
  input  logic [REG_W-1:0] sw_wdata,
  input  logic             hw_inc,
  input  logic             hw_err_ld,
  input  logic [1:0]       hw_err_code,
  output logic [REG_W-1:0] rd_word
);

  logic [1:0]       err_q, err_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             upd_en;
  logic             unused_wbits;

  assign unused_wbits = ^sw_wdata;

  always_comb begin
    err_d  = err_q;
    idx_d  = idx_q;
    upd_en = 1'b0;
    if (sw_we) begin
      err_d  = sw_wdata[ERR_HI:ERR_LO];
      idx_d  = sw_wdata[IDX_W-1:0];
      upd_en = 1'b1;
    end else if (hw_err_ld) begin
      err_d  = hw_err_code;
      upd_en = 1'b1;
    end else if (hw_inc) begin
      idx_d  = idx_q + 1'b1;
      upd_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= '0;
      idx_q <= '0;
    end else if (upd_en) begin
      err_q <= err_d;
      idx_q <= idx_d;
    end
  end

  for (genvar b = 0; b < REG_W; b++) begin : g_bit
    if (b >= ERR_LO) begin : g_err
      assign rd_word[b] = err_q[b-ERR_LO];
    end else if (b < IDX_W) begin : g_idx
      assign rd_word[b] = idx_q[b];
    end else begin : g_res
      assign rd_word[b] = 1'b0;
    end
  end

  // R11
  err_load_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_err_ld && !sw_we) |=> (rd_word[ERR_HI:ERR_LO] == $past(hw_err_code))
                              && (rd_word[IDX_W-1:0] == $past(rd_word[IDX_W-1:0])));

  // R10
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_inc && !hw_err_ld && !sw_we) |=>
      (rd_word[IDX_W-1:0] == IDX_W'($past(rd_word[IDX_W-1:0]) + 1'b1)));

  // R11
  sw_over_hw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_we |=> (rd_word[ERR_HI:ERR_LO] == $past(sw_wdata[ERR_HI:ERR_LO])));

endmodule

// File: rtl/acg_resp.sv
module acg_resp
  import acg_pkg::*;
#(
  parameter int unsigned        OFFS_W       = 12,
  parameter logic [OFFS_W-1:0]  REDIR_OFFSET = 12'h308
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  acg_outcome_e      outcome,
  input  logic [REG_W-1:0]  reg_word,
  output logic              rsp_valid,
  output logic              rsp_write,
  output logic              rsp_direct,
  output logic              rsp_redirect,
  output logic              rsp_trap_l2,
  output logic              rsp_trap_l3,
  output logic              rsp_undef,
  output logic [SYN_W-1:0]  rsp_syndrome,
  output logic [OFFS_W-1:0] rsp_mem_offset,
  output logic [REG_W-1:0]  rsp_rdata
);

  logic              valid_d, write_d;
  logic [4:0]        flags_d, flags_q;
  logic [SYN_W-1:0]  syn_d;
  logic [OFFS_W-1:0] offs_d;
  logic [REG_W-1:0]  rdata_d;

  always_comb begin
    valid_d = req_valid;
    write_d = req_valid && req_write;
    flags_d = '0;
    syn_d   = '0;
    offs_d  = '0;
    rdata_d = '0;
    if (req_valid) begin
      unique case (outcome)
        OC_DIRECT: begin
          flags_d[0] = 1'b1;
          if (!req_write) rdata_d = reg_word;
        end
        OC_REDIRECT: begin
          flags_d[1] = 1'b1;
          offs_d     = REDIR_OFFSET;
        end
        OC_TRAP_L2: begin
          flags_d[2] = 1'b1;
          syn_d      = SYN_SYSREG;
        end
        OC_TRAP_L3: begin
          flags_d[3] = 1'b1;
          syn_d      = SYN_SYSREG;
        end
        default: flags_d[4] = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid      <= 1'b0;
      rsp_write      <= 1'b0;
      flags_q        <= '0;
      rsp_syndrome   <= '0;
      rsp_mem_offset <= '0;
      rsp_rdata      <= '0;
    end else begin
      rsp_valid      <= valid_d;
      rsp_write      <= write_d;
      flags_q        <= flags_d;
      rsp_syndrome   <= syn_d;
      rsp_mem_offset <= offs_d;
      rsp_rdata      <= rdata_d;
    end
  end

  assign rsp_direct   = flags_q[0];
  assign rsp_redirect = flags_q[1];
  assign rsp_trap_l2  = flags_q[2];
  assign rsp_trap_l3  = flags_q[3];
  assign rsp_undef    = flags_q[4];

  // R8
  outcome_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $onehot({rsp_direct, rsp_redirect, rsp_trap_l2, rsp_trap_l3, rsp_undef}));

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> ($countones({rsp_direct, rsp_redirect, rsp_trap_l2, rsp_trap_l3, rsp_undef}) == 0)
                   && (rsp_rdata == '0) && !rsp_write);

  // R4
  trap_syndrome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_trap_l2 || rsp_trap_l3) |-> (rsp_syndrome == SYN_SYSREG));

endmodule

// File: rtl/ctlreg_access_gate.sv
module ctlreg_access_gate
  import acg_pkg::*;
#(
  parameter int unsigned       IDX_W        = 12,
  parameter int unsigned       OFFS_W       = 12,
  parameter logic [OFFS_W-1:0] REDIR_OFFSET = 12'h308
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [63:0]       req_wdata,
  input  logic [1:0]        priv_lvl,
  input  logic [2:0]        nv_ctl,
  input  logic              feat_impl,
  input  logic              top_lvl_present,
  input  logic              top_lvl_enable,
  input  logic              undef_prio_mode,
  input  logic              undef_secondary,
  input  logic              hw_idx_inc,
  input  logic              hw_err_load,
  input  logic [1:0]        hw_err_code,
  output logic              rsp_valid,
  output logic              rsp_write,
  output logic              rsp_direct,
  output logic              rsp_redirect,
  output logic              rsp_trap_l2,
  output logic              rsp_trap_l3,
  output logic              rsp_undef,
  output logic [5:0]        rsp_syndrome,
  output logic [OFFS_W-1:0] rsp_mem_offset,
  output logic [63:0]       rsp_rdata
);

  logic         rst_meta_q, rst_sync_n;
  acg_outcome_e outcome;
  logic         sw_we;
  logic [63:0]  reg_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  acg_decide u_decide (
    .feat_impl   (feat_impl),
    .priv_lvl    (priv_lvl),
    .nv_ctl      (nv_ctl),
    .top_present (top_lvl_present),
    .top_enable  (top_lvl_enable),
    .prio_mode   (undef_prio_mode),
    .sec_undef   (undef_secondary),
    .outcome     (outcome)
  );

  assign sw_we = req_valid && req_write && (outcome == OC_DIRECT);

  acg_consreg #(.IDX_W(IDX_W)) u_reg (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .sw_we       (sw_we),
    .sw_wdata    (req_wdata),
    .hw_inc      (hw_idx_inc),
    .hw_err_ld   (hw_err_load),
    .hw_err_code (hw_err_code),
    .rd_word     (reg_word)
  );

  acg_resp #(.OFFS_W(OFFS_W), .REDIR_OFFSET(REDIR_OFFSET)) u_resp (
    .clk            (clk),
    .rst_n          (rst_sync_n),
    .req_valid      (req_valid),
    .req_write      (req_write),
    .outcome        (outcome),
    .reg_word       (reg_word),
    .rsp_valid      (rsp_valid),
    .rsp_write      (rsp_write),
    .rsp_direct     (rsp_direct),
    .rsp_redirect   (rsp_redirect),
    .rsp_trap_l2    (rsp_trap_l2),
    .rsp_trap_l3    (rsp_trap_l3),
    .rsp_undef      (rsp_undef),
    .rsp_syndrome   (rsp_syndrome),
    .rsp_mem_offset (rsp_mem_offset),
    .rsp_rdata      (rsp_rdata)
  );

  // R1
  nofeat_undef_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && !feat_impl) |=> rsp_undef);

  // R2
  lvl0_undef_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && priv_lvl == 2'd0) |=> rsp_undef);

  // R3
  redir_keeps_reg_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && req_write && outcome == OC_REDIRECT && !hw_idx_inc && !hw_err_load)
      |=> $stable(reg_word));

  // R9
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rsp_rdata[61:IDX_W] == '0);

  // R7
  lvl3_direct_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && feat_impl && priv_lvl == 2'd3) |=> rsp_direct);

endmodule

// File: tb/ctlreg_access_gate_tb.sv
module ctlreg_access_gate_tb;

  localparam int IDX_W = 12;

  logic        clk;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [63:0] req_wdata;
  logic [1:0]  priv_lvl;
  logic [2:0]  nv_ctl;
  logic        feat_impl, top_lvl_present, top_lvl_enable;
  logic        undef_prio_mode, undef_secondary;
  logic        hw_idx_inc, hw_err_load;
  logic [1:0]  hw_err_code;
  logic        rsp_valid, rsp_write, rsp_direct, rsp_redirect;
  logic        rsp_trap_l2, rsp_trap_l3, rsp_undef;
  logic [5:0]  rsp_syndrome;
  logic [11:0] rsp_mem_offset;
  logic [63:0] rsp_rdata;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  // behavioural model state
  int unsigned m_err = 0;
  int unsigned m_idx = 0;

  ctlreg_access_gate #(.IDX_W(IDX_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_wdata(req_wdata), .priv_lvl(priv_lvl), .nv_ctl(nv_ctl),
    .feat_impl(feat_impl), .top_lvl_present(top_lvl_present),
    .top_lvl_enable(top_lvl_enable), .undef_prio_mode(undef_prio_mode),
    .undef_secondary(undef_secondary), .hw_idx_inc(hw_idx_inc),
    .hw_err_load(hw_err_load), .hw_err_code(hw_err_code),
    .rsp_valid(rsp_valid), .rsp_write(rsp_write), .rsp_direct(rsp_direct),
    .rsp_redirect(rsp_redirect), .rsp_trap_l2(rsp_trap_l2),
    .rsp_trap_l3(rsp_trap_l3), .rsp_undef(rsp_undef),
    .rsp_syndrome(rsp_syndrome), .rsp_mem_offset(rsp_mem_offset),
    .rsp_rdata(rsp_rdata)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual cycles=%0d expected <=50000", cyc);
      summary();
    end
  end

  // 0 direct, 1 redirect, 2 trap L2, 3 trap L3, 4 undef
  function automatic int ref_outcome();
    if (!feat_impl) return 4;
    if (priv_lvl == 0) return 4;
    if (priv_lvl == 1) begin
      if (nv_ctl[0] && nv_ctl[2]) return 1;
      if (nv_ctl[0]) return 2;
      return 4;
    end
    if (priv_lvl == 2 && top_lvl_present && !top_lvl_enable) begin
      if (undef_prio_mode || undef_secondary) return 4;
      return 3;
    end
    return 0;
  endfunction

  function automatic logic [63:0] model_word();
    logic [63:0] w;
    w = '0;
    w[63:62] = m_err[1:0];
    w[IDX_W-1:0] = m_idx[IDX_W-1:0];
    return w;
  endfunction

  // one clock: expected from driven inputs and pre-edge model, compare after edge
  task automatic step(string tag);
    int          oc;
    logic [4:0]  e_flags, a_flags;
    logic [63:0] e_rdata;
    logic [5:0]  e_syn;
    logic [11:0] e_off;
    logic        e_valid, e_wr;
    oc      = ref_outcome();
    e_valid = req_valid;
    e_wr    = req_valid && req_write;
    e_flags = '0;
    e_rdata = '0;
    e_syn   = '0;
    e_off   = '0;
    if (req_valid) begin
      e_flags[oc] = 1'b1;
      if (oc == 0 && !req_write) e_rdata = model_word();
      if (oc == 2 || oc == 3) e_syn = 6'h18;
      if (oc == 1) e_off = 12'h308;
    end
    @(posedge clk);
    if (req_valid && req_write && oc == 0) begin
      m_err = int'(req_wdata[63:62]);
      m_idx = int'(req_wdata[IDX_W-1:0]);
    end else if (hw_err_load) begin
      m_err = int'(hw_err_code);
    end else if (hw_idx_inc) begin
      m_idx = (m_idx + 1) % (1 << IDX_W);
    end
    @(negedge clk);
    a_flags = {rsp_undef, rsp_trap_l3, rsp_trap_l2, rsp_redirect, rsp_direct};
    checks++;
    if (a_flags !== e_flags || rsp_rdata !== e_rdata || rsp_syndrome !== e_syn ||
        rsp_mem_offset !== e_off || rsp_valid !== e_valid || rsp_write !== e_wr) begin
      fails++;
      $display("FAIL %s: actual v=%b w=%b flags=%b syn=%h off=%h rd=%h expected v=%b w=%b flags=%b syn=%h off=%h rd=%h",
               tag, rsp_valid, rsp_write, a_flags, rsp_syndrome, rsp_mem_offset, rsp_rdata,
               e_valid, e_wr, e_flags, e_syn, e_off, e_rdata);
    end
  endtask

  task automatic idle_inputs();
    req_valid = 0; req_write = 0; req_wdata = '0; priv_lvl = 2'd3; nv_ctl = '0;
    feat_impl = 1; top_lvl_present = 1; top_lvl_enable = 1;
    undef_prio_mode = 0; undef_secondary = 0;
    hw_idx_inc = 0; hw_err_load = 0; hw_err_code = '0;
  endtask

  task automatic access(string tag, logic [1:0] lvl, logic wr, logic [63:0] wd);
    req_valid = 1; req_write = wr; req_wdata = wd; priv_lvl = lvl;
    step(tag);
    req_valid = 0; req_write = 0;
  endtask

  initial begin
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R8 idle, R9 reset value
    step("R8");
    access("R9", 2'd3, 0, '0);

    // R9 reserved bits masked, R7 direct write and read at level 3
    access("R7", 2'd3, 1, 64'hFFFF_FFFF_FFFF_FFFF);
    access("R9", 2'd3, 0, '0);
    access("R7", 2'd3, 1, 64'h8000_0000_0000_0ABC);
    access("R7", 2'd3, 0, '0);

    // R7 level 2 with top level absent, then enabled
    top_lvl_present = 0;
    access("R7", 2'd2, 1, 64'h4000_0000_0000_0123);
    access("R7", 2'd2, 0, '0);
    top_lvl_present = 1; top_lvl_enable = 1;
    access("R7", 2'd2, 0, '0);

    // R1 feature absent masks all levels and controls
    feat_impl = 0;
    for (int l = 0; l < 4; l++) begin
      nv_ctl = 3'b101;
      access("R1", 2'(l), 1, 64'h0);
      access("R1", 2'(l), 0, '0);
    end
    feat_impl = 1;
    access("R1", 2'd3, 0, '0);

    // R2 level 0 under all nested controls
    for (int n = 0; n < 8; n++) begin
      nv_ctl = 3'(n);
      access("R2", 2'd0, n[0], 64'hC000_0000_0000_0FFF);
    end

    // R3 / R4 level 1 all nested-control combinations
    for (int n = 0; n < 8; n++) begin
      nv_ctl = 3'(n);
      access((n == 5 || n == 7) ? "R3" : "R4", 2'd1, 0, '0);
      access((n == 5 || n == 7) ? "R3" : "R4", 2'd1, 1, 64'hFFFF_0000_0000_0555);
      access("R3", 2'd3, 0, '0);
    end
    nv_ctl = '0;

    // R5 / R6 / R7 level 2 all top-level combinations
    for (int c = 0; c < 16; c++) begin
      top_lvl_present = c[0]; top_lvl_enable = c[1];
      undef_prio_mode = c[2]; undef_secondary = c[3];
      access(c[2] ? "R5" : "R6", 2'd2, 0, '0);
      access(c[2] ? "R5" : "R6", 2'd2, 1, 64'h0000_0000_0000_0077);
    end
    top_lvl_present = 1; top_lvl_enable = 1; undef_prio_mode = 0; undef_secondary = 0;
    access("R7", 2'd3, 0, '0);

    // R10 increment and wrap
    access("R10", 2'd3, 1, 64'h4000_0000_0000_0FFE);
    hw_idx_inc = 1;
    step("R10");
    step("R10");
    step("R10");
    hw_idx_inc = 0;
    access("R10", 2'd3, 0, '0);

    // R11 error load beats increment
    hw_idx_inc = 1; hw_err_load = 1; hw_err_code = 2'd2;
    step("R11");
    hw_idx_inc = 0; hw_err_load = 0;
    access("R11", 2'd3, 0, '0);
    // R11 software write beats both hardware updates
    hw_idx_inc = 1; hw_err_load = 1; hw_err_code = 2'd3;
    access("R11", 2'd3, 1, 64'h4000_0000_0000_0010);
    hw_idx_inc = 0; hw_err_load = 0;
    access("R11", 2'd3, 0, '0);
    // R11 hardware load while a redirected write is refused for the register
    hw_err_load = 1; hw_err_code = 2'd1; nv_ctl = 3'b111;
    access("R11", 2'd1, 1, 64'hFFFF_FFFF_FFFF_FFFF);
    hw_err_load = 0; nv_ctl = '0;
    access("R11", 2'd3, 0, '0);

    // R8 random phase, all inputs free
    for (int i = 0; i < 2000; i++) begin
      req_valid = 1'($urandom); req_write = 1'($urandom);
      req_wdata = {$urandom, $urandom};
      priv_lvl = 2'($urandom); nv_ctl = 3'($urandom);
      feat_impl = ($urandom % 8) != 0;
      top_lvl_present = 1'($urandom); top_lvl_enable = 1'($urandom);
      undef_prio_mode = 1'($urandom); undef_secondary = 1'($urandom);
      hw_idx_inc = 1'($urandom); hw_err_load = ($urandom % 4) == 0;
      hw_err_code = 2'($urandom);
      step("R8");
    end
    idle_inputs();
    step("R8");

    summary();
  end

endmodule